// File: doc/BRIEF.md
# Repeated-Addition Sequential Multiplier

This block forms the unsigned product of two operands one addition at a time. A start pulse captures the multiplicand in a holding register, loads the multiplier into a down counter and clears the product register. Each following clock adds the held multiplicand into the product and decrements the counter. When the counter reads zero, the block stops and raises a done flag. Latency follows the multiplier's value: a multiplier of n takes n+1 cycles from the accepting edge to done.

The operand width is a parameter. The product is twice that width, so no operand pair can overflow it. A second parameter chooses how the single adder is built: either a behavioural sum or an explicit ripple chain of full-adder cells. Both choices give the same results.

Top module: `mulrep_top`

## Requirements
- R1: After reset, busy_o, done_o and product_o are all 0.
- R2: A start_i sampled high while the block is not busy is accepted. After that edge, busy_o is 1, done_o is 0 and product_o is 0. This also applies when done_o was high.
- R3: On each clock edge where the block is busy and the counter is nonzero, product_o grows by the held multiplicand exactly once. After k such edges, product_o equals multiplicand times k.
- R4: done_o rises on the edge that finds the counter at zero. For a multiplier b, this is edge b+1 after the accepting edge, and product_o then equals multiplicand times multiplier (7 x 5 = 35, 5 x 4 = 20).
- R5: With a multiplier of 0, done_o is 1 one cycle after the load, and product_o is 0.
- R6: While done_o is 1 and start_i is low, done_o stays 1 and product_o does not change.
- R7: A start_i pulse while busy_o is 1 is ignored. The running operation goes on and ends with its own operands' product and latency.
- R8: product_o is 2*OP_W bits wide. The largest operands (255 x 255 = 65025 for OP_W = 8) produce the exact product with no carry lost.
- R9: mcand_i and mplier_i are sampled only on an accepted start. Changing them during an operation has no effect on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; ignored while busy |
| mcand_i | input | OP_W | Multiplicand, captured on accepted start |
| mplier_i | input | OP_W | Multiplier, loaded into the down counter on accepted start |
| busy_o | output | 1 | High while additions are in progress |
| done_o | output | 1 | High from completion until the next accepted start |
| product_o | output | 2*OP_W | Accumulated product |

## Verification
The bench targets a zero multiplier, where a design that performs one spurious addition or waits an extra cycle would show a nonzero product or late done. It also covers the largest operand pair, where a product register that is too narrow or an adder missing its top carry would return a truncated value. Start pulses injected mid-operation and operand inputs scrambled while busy expose a design that restarts or resamples inputs. Back-to-back runs started from the done state catch a product that is not cleared on restart. Every operation's completion edge is compared with the multiplier's value, so an off-by-one in the counter shows up as a latency mismatch.

// File: rtl/mulrep_pkg.sv
package mulrep_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_DONE = 2'd2
   } mul_state_e;
endpackage

// File: rtl/mulrep_hold_reg.sv
module mulrep_hold_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_o <= '0;
      else if (load_i) q_o <= d_i;
   end

   // R9: the held multiplicand only changes on a load
   p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(q_o));
endmodule

// File: rtl/mulrep_down_cnt.sv
module mulrep_down_cnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic         dec_i,
   output logic         zero_o
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (load_i)            cnt_q <= load_val_i;
      else if (dec_i && !zero_o)  cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

   // R3: one step down per active cycle
   p_count_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_i && !load_i && !zero_o) |=> (cnt_q == W'($past(cnt_q) - 1'b1)));
endmodule

// File: rtl/mulrep_accum.sv
module mulrep_accum #(
   parameter int W          = 8,
   parameter bit USE_RIPPLE = 1'b0,
   localparam int PW        = 2 * W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          add_i,
   input  logic [W-1:0]  addend_i,
   output logic [PW-1:0] prod_o
);
   logic [PW-1:0] addend_ext;
   logic [PW-1:0] sum;
   logic          carry_out;

   assign addend_ext = {{(PW-W){1'b0}}, addend_i};

   generate
      if (USE_RIPPLE) begin : g_ripple
         logic [PW:0] c;
         assign c[0] = 1'b0;
         for (genvar i = 0; i < PW; i++) begin : g_fa
            assign sum[i]   = prod_o[i] ^ addend_ext[i] ^ c[i];
            assign c[i+1]   = (prod_o[i] & addend_ext[i]) |
                              (c[i] & (prod_o[i] ^ addend_ext[i]));
         end
         assign carry_out = c[PW];
      end else begin : g_behav
         assign {carry_out, sum} = {1'b0, prod_o} + {1'b0, addend_ext};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      prod_o <= '0;
      else if (clr_i)  prod_o <= '0;
      else if (add_i)  prod_o <= sum;
   end

   // R8: the double-width product never loses a carry
   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      add_i |-> !carry_out);
endmodule

// File: rtl/mulrep_top.sv
module mulrep_top
   import mulrep_pkg::*;
#(
   parameter int OP_W       = 8,
   parameter bit USE_RIPPLE = 1'b0,
   localparam int PROD_W    = 2 * OP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [OP_W-1:0]   mcand_i,
   input  logic [OP_W-1:0]   mplier_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [PROD_W-1:0] product_o
);
   generate
      if (OP_W < 1) begin : g_bad_width
         $error("mulrep_top: OP_W must be at least 1");
      end
   endgenerate

   mul_state_e    state_q;
   logic          accept;
   logic          cnt_zero;
   logic          do_add;
   logic [OP_W-1:0] mcand_q;

   assign accept = start_i && (state_q != ST_RUN);
   assign do_add = (state_q == ST_RUN) && !cnt_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
      end else begin
         unique case (state_q)
            ST_RUN:  if (cnt_zero) state_q <= ST_DONE;
            default: if (start_i)  state_q <= ST_RUN;
         endcase
      end
   end

   mulrep_hold_reg #(.W(OP_W)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (accept),
      .d_i    (mcand_i),
      .q_o    (mcand_q)
   );

   mulrep_down_cnt #(.W(OP_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (accept),
      .load_val_i (mplier_i),
      .dec_i      (do_add),
      .zero_o     (cnt_zero)
   );

   mulrep_accum #(.W(OP_W), .USE_RIPPLE(USE_RIPPLE)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (accept),
      .add_i    (do_add),
      .addend_i (mcand_q),
      .prod_o   (product_o)
   );

   assign busy_o = (state_q == ST_RUN);
   assign done_o = (state_q == ST_DONE);

   // R2: an accepted start clears the product and enters the busy phase
   p_clear_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> (busy_o && !done_o && product_o == '0));

   // R4: an exhausted counter completes the operation on the next edge
   p_done_after_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && cnt_zero) |=> done_o);

   // R6: the result is held until a new start
   p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> (done_o && $stable(product_o)));

   // R7: a start during an operation does not disturb it
   p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && !cnt_zero) |=> busy_o);

   // R1: outputs are mutually exclusive flags
   p_flags_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_o && done_o));
endmodule

// File: tb/mulrep_top_tb_top.sv
module mulrep_top_tb_top;
   localparam int CLK_P = 10;
   localparam int W     = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [W-1:0]   a = '0;
   logic [W-1:0]   b = '0;
   logic           busy, done;
   logic [2*W-1:0] prod;

   int     n_chk = 0;
   int     n_err = 0;
   int     cyc   = 0;
   longint exp_prod_q[$];
   longint exp_cyc_q[$];
   logic   done_prev = 1'b0;

   mulrep_top #(.OP_W(W)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start),
      .mcand_i   (a),
      .mplier_i  (b),
      .busy_o    (busy),
      .done_o    (done),
      .product_o (prod)
   );

   initial forever #(CLK_P/2) clk = ~clk;
   always @(posedge clk) cyc = cyc + 1;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   // monitor: pops the scoreboard on each completion
   always @(negedge clk) begin
      if (rst_n && done && !done_prev) begin
         if (exp_prod_q.size() == 0) begin
            check(1'b0, "R4 unexpected done", 1, 0);
         end else begin
            longint ep, ec;
            ep = exp_prod_q.pop_front();
            ec = exp_cyc_q.pop_front();
            check(longint'(prod) == ep, "R4 product", longint'(prod), ep);
            check(longint'(cyc) == ec, "R4 latency", longint'(cyc), ec);
         end
      end
      done_prev = done;
   end

   // driver: launches one operation and pushes its expectation
   task automatic run_op(input int av, input int bv, input bit inject);
      int k;
      @(negedge clk);
      a = W'(av); b = W'(bv); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R2 busy after start", busy, 1);
      check(done == 1'b0, "R2 done cleared", done, 0);
      exp_prod_q.push_back(longint'(av) * longint'(bv));
      exp_cyc_q.push_back(longint'(cyc) + bv + 1);
      a = ~W'(av); b = ~W'(bv);   // R9: inputs scrambled while busy
      k = 0;
      forever begin
         check(longint'(prod) == longint'(av) * ((k < bv) ? k : bv),
               "R3 partial product", longint'(prod), longint'(av) * ((k < bv) ? k : bv));
         if (bv == 0 && k == 1) check(done == 1'b1 && prod == '0, "R5 zero multiplier", done, 1);
         if (done) break;
         start = (inject && k == 1 && busy);   // R7: start while busy
         @(negedge clk);
         k++;
         if (k > 300) begin
            check(1'b0, "R4 no completion", k, bv + 1);
            break;
         end
      end
      start = 1'b0;
      check(longint'(prod) == longint'(av) * bv, "R9 result uses captured operands",
            longint'(prod), longint'(av) * bv);
      for (int h = 0; h < 3; h++) begin
         longint held;
         held = longint'(prod);
         @(negedge clk);
         check(done == 1'b1 && longint'(prod) == held, "R6 result held", longint'(prod), held);
      end
   endtask

   task automatic finish_sim();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   endtask

   initial begin
      #(CLK_P * 100000);
      check(1'b0, "watchdog", 0, 1);
      finish_sim();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(busy == 1'b0, "R1 reset busy", busy, 0);
      check(done == 1'b0, "R1 reset done", done, 0);
      check(prod == '0, "R1 reset product", longint'(prod), 0);

      run_op(7, 5, 1'b0);       // R4: 35
      run_op(5, 4, 1'b0);       // R4: 20, restarted from done (R2)
      run_op(9, 0, 1'b0);       // R5
      run_op(255, 255, 1'b0);   // R8: 65025
      run_op(0, 200, 1'b0);
      run_op(13, 1, 1'b0);
      run_op(3, 6, 1'b1);       // R7
      run_op(200, 17, 1'b1);    // R7
      run_op(1, 0, 1'b1);       // R7 at zero multiplier

      repeat (2) @(negedge clk);
      check(exp_prod_q.size() == 0, "R4 all operations completed", exp_prod_q.size(), 0);
      finish_sim();
   end
endmodule